// File: doc/BRIEF.md
# Fractional 100 Hz Tick Generator

This block turns a stream of input strobes at the crystal rate into a one-cycle tick at exactly 100 Hz on average. An integer prescaler first brings the 32.768 kHz strobe down to a 4096 Hz base rate. A mixed-modulus sequencer then counts base strobes. It runs twenty-four periods of 41 and then one period of 40, so twenty-five ticks take exactly 1024 base strobes. Each tick is therefore late by up to a fraction of a base period. The error returns to zero every quarter second.

A side tap divides the base rate by four to give a 1024 Hz square wave. A halt input models a stopped oscillator: it freezes every counter in place, and the sequence resumes from that point when the halt is released.

All pins are plain control strobes and levels. No data word flows through the block, so there is no valid/ready handshake. The input strobe is counted on any clock edge where it is high and halt is low. Reset is synchronous and active high.

Top module: `frac_tick_div`

## Requirements
- R1: While `rst` is high at a clock edge, all counters clear to zero, and after that edge `tick100_o` and `sq1024_o` are 0.
- R2: With the default parameters, one base strobe is formed for every 8 accepted input strobes. An input strobe is accepted when `strobe_i` is 1 and `halt_i` is 0 at a rising clock edge.
- R3: The sequence slots are numbered 0 to 24, starting at 0 after reset. In slots 0 to 23 a tick is issued on every 41st base strobe, which is 328 accepted input strobes.
- R4: Slot 24 is the last slot and uses a period of 40 base strobes (320 input strobes). After it, the sequence returns to slot 0.
- R5: Every 25 ticks span exactly 1024 base strobes, which is 8192 accepted input strobes counted from reset.
- R6: `tick100_o` is high for exactly one clock cycle. It follows the edge that accepts the input strobe completing a period.
- R7: Let b be the number of base strobes since reset, taken modulo 4. `sq1024_o` is 0 when b is 0 or 1 and is 1 when b is 2 or 3.
- R8: While `halt_i` is 1, `strobe_i` is ignored. No tick is issued, `sq1024_o` holds its value, and counting resumes from the same point after `halt_i` returns to 0.
- R9: A reset during a run restarts the sequence. The first tick after it comes 328 accepted input strobes after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Oscillator stopped: freeze all counters |
| strobe_i | input | 1 | One-cycle strobe at the crystal rate |
| tick100_o | output | 1 | One-cycle 100 Hz tick |
| sq1024_o | output | 1 | 1024 Hz square wave |

## Verification
The bound checker covers the per-cycle rules on every cycle:
- the tick lasts a single cycle;
- a tick only follows an accepted strobe;
- halt suppresses the tick and freezes the square wave;
- the square wave changes only after an accepted strobe;
- the sequencer's internal counters never leave their ranges.

Other properties can only be shown by the bench's scenarios, which compare against a strobe-counting reference model:
- the exact spacing of 328 and 320 strobes and where the short period falls;
- the 8192-strobe realignment after 25 ticks;
- the restart after a reset in mid-run.

These scenarios use a dense strobe, a sparse strobe and halt windows.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;
  localparam int unsigned DEF_PRE_DIV  = 8;
  localparam int unsigned DEF_MOD_LONG = 41;
  localparam int unsigned DEF_SEQ_LEN  = 25;
  localparam int unsigned DEF_SQ_DIV   = 4;

  typedef struct packed {
    logic base_stb;
    logic period_end;
  } seq_evt_t;
endpackage

// File: rtl/frac_prescale.sv
module frac_prescale #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic halt_i,
  input  logic strobe_i,
  output logic base_stb_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic accept;
  assign accept = strobe_i && !halt_i;

  generate
    if (DIV <= 1) begin : g_pass
      assign base_stb_o = accept;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      logic          wrap;
      assign wrap = (cnt_q == CW'(DIV - 1));

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (accept) begin
          cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
      end

      assign base_stb_o = accept && wrap;
    end
  endgenerate
endmodule

// File: rtl/frac_ratio_seq.sv
module frac_ratio_seq
  import frac_tick_pkg::*;
#(
  parameter int unsigned MOD_LONG = 41,
  parameter int unsigned SEQ_LEN  = 25
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     base_stb_i,
  output seq_evt_t evt_o,
  output logic     tick_o
);
  localparam int unsigned MOD_SHORT = MOD_LONG - 1;
  localparam int unsigned MW        = $clog2(MOD_LONG);
  localparam int unsigned SW        = $clog2(SEQ_LEN);

  logic [MW-1:0] mod_q;
  logic [SW-1:0] slot_q;
  logic          last_slot;
  logic [MW-1:0] limit;
  logic          period_end;

  assign last_slot  = (slot_q == SW'(SEQ_LEN - 1));
  assign limit      = last_slot ? MW'(MOD_SHORT - 1) : MW'(MOD_LONG - 1);
  assign period_end = (mod_q == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_q  <= '0;
      slot_q <= '0;
    end else if (base_stb_i) begin
      if (period_end) begin
        mod_q  <= '0;
        slot_q <= last_slot ? '0 : slot_q + 1'b1;
      end else begin
        mod_q <= mod_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= base_stb_i && period_end;
  end

  assign evt_o.base_stb   = base_stb_i;
  assign evt_o.period_end = period_end;
endmodule

// File: rtl/frac_sq_div.sv
module frac_sq_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic base_stb_i,
  output logic sq_o
);
  localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned HALF = DIV / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (base_stb_i) begin
      cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign sq_o = (cnt_q >= CW'(HALF));
endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div
  import frac_tick_pkg::*;
#(
  parameter int unsigned PRE_DIV  = DEF_PRE_DIV,
  parameter int unsigned MOD_LONG = DEF_MOD_LONG,
  parameter int unsigned SEQ_LEN  = DEF_SEQ_LEN,
  parameter int unsigned SQ_DIV   = DEF_SQ_DIV
) (
  input  logic clk,
  input  logic rst,
  input  logic halt_i,
  input  logic strobe_i,
  output logic tick100_o,
  output logic sq1024_o
);
  logic     base_stb;
  seq_evt_t evt;
  logic     evt_unused;

  frac_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .halt_i(halt_i), .strobe_i(strobe_i),
    .base_stb_o(base_stb)
  );

  frac_ratio_seq #(.MOD_LONG(MOD_LONG), .SEQ_LEN(SEQ_LEN)) u_seq (
    .clk(clk), .rst(rst), .base_stb_i(base_stb), .evt_o(evt),
    .tick_o(tick100_o)
  );

  frac_sq_div #(.DIV(SQ_DIV)) u_sq (
    .clk(clk), .rst(rst), .base_stb_i(base_stb), .sq_o(sq1024_o)
  );

  assign evt_unused = ^evt;
endmodule

// File: rtl/frac_tick_div_chk.sv
module frac_tick_div_chk #(
  parameter int unsigned MW       = 6,
  parameter int unsigned SW       = 5,
  parameter int unsigned MOD_LONG = 41,
  parameter int unsigned SEQ_LEN  = 25
) (
  input logic          clk,
  input logic          rst,
  input logic          halt_i,
  input logic          strobe_i,
  input logic          tick100_o,
  input logic          sq1024_o,
  input logic [MW-1:0] mod_q,
  input logic [SW-1:0] slot_q
);
  // R6: a tick never lasts two cycles
  p_single_tick_r6: assert property (@(posedge clk) disable iff (rst)
    tick100_o |=> !tick100_o);

  // R6: a tick only follows an accepted strobe
  p_tick_after_stb_r6: assert property (@(posedge clk) disable iff (rst)
    (tick100_o && !$past(rst)) |-> $past(strobe_i && !halt_i));

  // R8: halt suppresses ticks
  p_halt_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> !tick100_o);

  // R8: halt freezes the square wave
  p_halt_sq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> $stable(sq1024_o));

  // R7: square wave moves only after an accepted strobe
  p_sq_on_stb_r7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sq1024_o) && !$past(rst)) |-> $past(strobe_i && !halt_i));

  // R3: period counter stays below the long modulus
  p_mod_range_r3: assert property (@(posedge clk) disable iff (rst)
    mod_q < MW'(MOD_LONG));

  // R4: slot counter stays within the sequence
  p_slot_range_r4: assert property (@(posedge clk) disable iff (rst)
    slot_q < SW'(SEQ_LEN));
endmodule

bind frac_tick_div frac_tick_div_chk #(
  .MW($clog2(MOD_LONG)), .SW($clog2(SEQ_LEN)),
  .MOD_LONG(MOD_LONG), .SEQ_LEN(SEQ_LEN)
) u_chk (
  .clk(clk), .rst(rst), .halt_i(halt_i), .strobe_i(strobe_i),
  .tick100_o(tick100_o), .sq1024_o(sq1024_o),
  .mod_q(u_seq.mod_q), .slot_q(u_seq.slot_q)
);

// File: tb/frac_tick_div_bench.sv
module frac_tick_div_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_i = 1'b0;
  logic strobe_i = 1'b0;
  logic tick100_o, sq1024_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  int  n = 0;          // accepted input strobes since reset
  bit  exp_tick = 0;
  bit  exp_sq = 0;
  int  last_n = 0;
  int  tick_idx = 0;
  bit  prev_tick = 0;

  always #10 clk = ~clk;

  frac_tick_div u_frac_tick_div (
    .clk(clk), .rst(rst), .halt_i(halt_i), .strobe_i(strobe_i),
    .tick100_o(tick100_o), .sq1024_o(sq1024_o)
  );

  function automatic bit is_boundary(int b);
    int r = b % 1024;
    return (r == 0) || ((r % 41 == 0) && (r <= 984));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      n = 0; exp_tick = 0; exp_sq = 0;
      last_n = 0; tick_idx = 0;
    end else if (strobe_i && !halt_i) begin
      n = n + 1;
      exp_tick = (n % 8 == 0) && is_boundary(n / 8);
      exp_sq = ((n / 8) % 4) >= 2;
    end else begin
      exp_tick = 0;
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(tick100_o == exp_tick, "R3 R4 R6 tick vs model", tick100_o, exp_tick);
      check(sq1024_o == exp_sq, "R2 R7 square vs model", sq1024_o, exp_sq);
      if (tick100_o && !rst) begin
        check(!prev_tick, "R6 one-cycle tick", 1, 0);
        if (tick_idx % 25 == 24)
          check(n - last_n == 320, "R4 short period", n - last_n, 320);
        else
          check(n - last_n == 328, "R3 long period", n - last_n, 328);
        tick_idx++;
        last_n = n;
        if (tick_idx % 25 == 0)
          check(n == (tick_idx / 25) * 8192, "R5 quarter-second realign", n, (tick_idx / 25) * 8192);
      end
      prev_tick = tick100_o;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    bit saved_sq;
    int ticks_seen;
    repeat (4) @(negedge clk);
    check(tick100_o == 0 && sq1024_o == 0, "R1 reset outputs", {tick100_o, sq1024_o}, 0);
    rst = 0;

    // dense strobe: over two full sequences
    strobe_i = 1;
    for (int i = 0; i < 16900; i++) @(negedge clk);
    check(tick_idx == 51, "R5 ticks after dense run", tick_idx, 51);

    // sparse strobe with halt windows
    for (int i = 0; i < 9000; i++) begin
      if (i % 1000 == 900) saved_sq = sq1024_o;
      if (i % 1000 == 999)
        check(sq1024_o == saved_sq, "R8 square held over halt", sq1024_o, saved_sq);
      strobe_i = (i % 3 == 0);
      halt_i = ((i % 1000) >= 900) && ((i % 1000) != 999);
      @(negedge clk);
    end
    halt_i = 0;

    // mid-run reset
    strobe_i = 0;
    rst = 1;
    @(negedge clk);
    check(tick100_o == 0 && sq1024_o == 0, "R1 R9 outputs after mid reset", {tick100_o, sq1024_o}, 0);
    rst = 0;
    strobe_i = 1;
    ticks_seen = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (tick100_o) begin
        ticks_seen++;
        if (ticks_seen == 1)
          check(n == 328, "R9 first tick after restart", n, 328);
      end
    end
    check(ticks_seen == 2, "R9 ticks after restart", ticks_seen, 2);
    finish_run();
  end
endmodule